// File: doc/BRIEF.md
# Counted Bus Transfer Sequencer

This block is the master-side sequencing engine of a two-wire serial bus controller. A control-register write sets up the transfer and starts it. The block then requests an address phase to a target. After that it moves bytes between a four-byte shared buffer and a byte-level bus agent, which handles start, send, receive and stop. Bit-level line timing belongs to that agent.

A transfer runs in one of two modes. In counted mode it ends when a running byte count reaches zero. At that point the sequencer either issues a stop or, with no stop requested, keeps the bus, drops the master bit and raises access-ready. In repeat mode the count is ignored: the sequencer drains or fills the buffer, raises a ready flag and waits. After every buffer access, and after every control write while it waits, the sequencer decides again what to do next. A requested stop closes the transfer.

Top module: `xfer_seq_top`

## Requirements
- R1: A control write with enable (bit 15), master (bit 10) and start (bit 0) set and 10-bit mode (bit 8) clear issues one START request to `tgtAddr`. `busRead` is 1 when transmit (bit 9) is 0. The start bit reads back as 0 and the buffer is emptied.
- R2: If the address phase is refused, status bit 1 (NACK) is set, stop (bit 1) is cleared and the bus is not left busy. If it is accepted, the running count is loaded from the programmed count.
- R3: In counted mode (repeat bit 2 clear), transmit sends bytes while the count is nonzero and bytes are pending, and each acknowledged byte lowers the count by one. When the buffer runs dry with count left, transmit-ready (status bit 4) is set. Counted receive takes bytes while the count is nonzero and fewer than 4 are held, and then sets receive-ready (status bit 3) if any byte is held.
- R4: At count zero, a pending stop sends a STOP request, clears the stop bit, reloads the count and discards untransmitted bytes, and the bus is then not busy. Without stop, access-ready (status bit 2) is set, the master bit reads back 0 and the bus stays busy.
- R5: In repeat mode the running count never changes. Transmit sends every pending byte and then sets transmit-ready. Receive fills the buffer to 4 bytes and then sets receive-ready. A pending stop ends the transfer.
- R6: A byte that is not acknowledged sets NACK and clears the stop bit, and no further byte of that burst is sent.
- R7: The control register reads back the written value ANDed with 0xCF87. With LEGACY_RESET=1, a control write with enable clear resets count, status, buffer and bus state.
- R8: A start request with the master bit clear, or with bit 8 set, issues no bus request and leaves the bus idle.
- R9: `cntCur` shows the running count, not the programmed value.
- R10: A little-endian word write sends data bits 7:0 first. With big-endian (bit 14) set, it sends bits 15:8 first. `datOut` shows the oldest held byte in bits 7:0 (swapped when big-endian). A read removes two bytes, and receive-ready clears when the buffer empties.
- R11: A buffer access or a control write while the sequencer is waiting makes it decide again. In repeat receive, a read that frees space causes new bytes to be fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| ctlWr | input | 1 | Control register write strobe |
| ctlIn | input | 16 | Control write value |
| ctlOut | output | 16 | Control register readback |
| cntWr | input | 1 | Programmed count write strobe |
| cntIn | input | 16 | Programmed count value |
| cntCur | output | 16 | Running count |
| tgtAddr | input | 10 | Target address |
| datWr | input | 1 | Buffer write strobe |
| datByte | input | 1 | Buffer write is one byte (bits 7:0) |
| datIn | input | 16 | Buffer write data |
| datRd | input | 1 | Buffer read strobe (removes two bytes) |
| datOut | output | 16 | Two oldest buffered bytes |
| statClr | input | 5 | Status bits to clear |
| status | output | 5 | Bit 1 NACK, 2 access-ready, 3 receive-ready, 4 transmit-ready |
| busBusy | output | 1 | Transfer holds the bus |
| busReq | output | 1 | One-cycle bus operation request |
| busOp | output | 2 | 0 start, 1 send, 2 receive, 3 stop |
| busAddr | output | 10 | Address for the start operation |
| busRead | output | 1 | Direction for the start operation |
| busWdata | output | 8 | Byte to send |
| busDone | input | 1 | Bus operation finished |
| busNack | input | 1 | Operation not acknowledged (valid with busDone) |
| busRdata | input | 8 | Received byte (valid with busDone) |

## Verification
The assertions assume three things about the environment. First, the bus agent answers each request with exactly one `busDone` and raises none without a request. Second, buffer accesses happen only while the sequencer is idle or waiting, not while an operation is in flight. Third, no control or count write lands in the same cycle as a `busDone`. The bench's bus model answers every request after a fixed latency, and the stimulus leaves a long settle gap after each register or buffer access. That way every access finds the sequencer at rest.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } busOp_e;

  localparam int B_EN  = 15;
  localparam int B_BE  = 14;
  localparam int B_MST = 10;
  localparam int B_TRX = 9;
  localparam int B_XA  = 8;
  localparam int B_RM  = 2;
  localparam int B_STP = 1;
  localparam int B_STT = 0;
  localparam logic [15:0] CTL_MASK = 16'hCF87;

  localparam int S_NACK = 1;
  localparam int S_ARDY = 2;
  localparam int S_RRDY = 3;
  localparam int S_XRDY = 4;

  // control -> datapath strobes
  typedef struct packed {
    logic       clrAll;
    logic       clrTx;
    logic       popTx;
    logic       pushRx;
    logic [7:0] rxByte;
  } dpCmd_t;

  // datapath -> control events
  typedef struct packed {
    logic wrFull;
    logic rdEmpty;
    logic bufEvent;
  } dpEv_t;
endpackage

// File: rtl/xfer_seq_dpath.sv
module xfer_seq_dpath
  import xfer_seq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int FW = DEPTH * 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCmd_t        cmd,
  input  logic          bigEnd,
  input  logic          datWr,
  input  logic          datByte,
  input  logic [15:0]   datIn,
  input  logic          datRd,
  output logic [15:0]   datOut,
  output logic [7:0]    txByte,
  output logic [LW-1:0] txLen,
  output logic [LW-1:0] rxLen,
  output dpEv_t         ev
);
  logic [FW-1:0] bufQ;
  logic [LW-1:0] txQ, rxQ;
  logic          wrOk;
  logic [LW-1:0] txIdx;
  logic [7:0]    hiB, loB;

  assign wrOk  = datWr && (txQ <= LW'(DEPTH - 2));
  assign txIdx = (txQ == '0) ? '0 : txQ - 1'b1;
  assign txByte = bufQ[int'(txIdx)*8 +: 8];
  assign hiB = bigEnd ? datIn[15:8] : datIn[7:0];
  assign loB = bigEnd ? datIn[7:0]  : datIn[15:8];
  assign datOut = bigEnd ? {bufQ[7:0], bufQ[15:8]} : {bufQ[15:8], bufQ[7:0]};

  assign txLen = txQ;
  assign rxLen = rxQ;
  assign ev.bufEvent = datWr || datRd;
  assign ev.wrFull   = wrOk && ((datByte ? txQ + 1'b1 : txQ + 2'd2) > LW'(DEPTH - 2));
  assign ev.rdEmpty  = datRd && (rxQ != '0) && (rxQ <= LW'(2));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufQ <= '0;
      txQ  <= '0;
      rxQ  <= '0;
    end else if (cmd.clrAll) begin
      bufQ <= '0;
      txQ  <= '0;
      rxQ  <= '0;
    end else if (cmd.clrTx) begin
      txQ <= '0;
    end else if (cmd.popTx) begin
      txQ <= txIdx;
    end else if (cmd.pushRx) begin
      bufQ[int'(rxQ)*8 +: 8] <= cmd.rxByte;
      rxQ <= rxQ + 1'b1;
    end else if (wrOk) begin
      if (datByte) begin
        bufQ <= {bufQ[FW-9:0], datIn[7:0]};
        txQ  <= txQ + 1'b1;
      end else begin
        bufQ <= {bufQ[FW-17:0], hiB, loB};
        txQ  <= txQ + 2'd2;
      end
    end else if (datRd && rxQ != '0) begin
      bufQ <= bufQ >> 16;
      rxQ  <= (rxQ >= LW'(2)) ? rxQ - 2'd2 : '0;
    end
  end

  // R10: lengths never exceed the buffer
  a_r10_len_bound: assert property (@(posedge clk) disable iff (!rstN)
    (txQ <= LW'(DEPTH)) && (rxQ <= LW'(DEPTH)));

  // R10: a word write into a nearly full buffer is dropped
  a_r10_full_ignored: assert property (@(posedge clk) disable iff (!rstN)
    datWr && (txQ > LW'(DEPTH - 2)) && !cmd.clrAll && !cmd.clrTx && !cmd.popTx
    |=> txQ == $past(txQ));
endmodule

// File: rtl/xfer_seq_ctrl.sv
module xfer_seq_ctrl
  import xfer_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int ADDR_W = 10,
  parameter int DEPTH = 4,
  parameter bit LEGACY_RESET = 1'b1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWr,
  input  logic [15:0]       ctlIn,
  output logic [15:0]       ctlOut,
  input  logic              cntWr,
  input  logic [CNT_W-1:0]  cntIn,
  output logic [CNT_W-1:0]  cntCur,
  input  logic [ADDR_W-1:0] tgtAddr,
  input  logic [4:0]        statClr,
  output logic [4:0]        status,
  output logic              busBusy,
  output logic              busReq,
  output logic [1:0]        busOp,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRead,
  input  logic              busDone,
  input  logic              busNack,
  input  logic [7:0]        busRdata,
  input  logic [LW-1:0]     txLen,
  input  logic [LW-1:0]     rxLen,
  input  dpEv_t             ev,
  output dpCmd_t            cmd
);
  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_RUN, ST_WAIT, ST_HOLD} state_e;

  state_e            stateQ, stateN;
  busOp_e            opQ, opN, issueOp;
  logic [15:0]       ctlQ, ctlN;
  logic [CNT_W-1:0]  cntPrgQ, cntPrgN, cntQ, cntN;
  logic [4:0]        statQ, statN;
  logic              busyQ, busyN, reqQ, reqN, readQ, readN;
  logic [ADDR_W-1:0] addrQ, addrN;
  logic              issue, finish, startReq;
  logic              cntZero, rxRoom;

  assign cntZero  = (cntQ == '0);
  assign rxRoom   = (rxLen < LW'(DEPTH));
  assign startReq = ctlIn[B_EN] && ctlIn[B_MST] && !ctlIn[B_XA] && ctlIn[B_STT];

  always_comb begin
    ctlN = ctlQ; cntPrgN = cntPrgQ; cntN = cntQ; statN = statQ & ~statClr;
    busyN = busyQ; stateN = stateQ; reqN = 1'b0; opN = opQ;
    readN = readQ; addrN = addrQ;
    issue = 1'b0; issueOp = OP_STOP; finish = 1'b0;
    cmd = '0;
    cmd.rxByte = busRdata;
    if (ev.wrFull)  statN[S_XRDY] = 1'b0;
    if (ev.rdEmpty) statN[S_RRDY] = 1'b0;

    unique case (stateQ)
      ST_ADDR: if (busDone) begin
        if (busNack) begin
          statN[S_NACK] = 1'b1;
          ctlN[B_STP] = 1'b0;
          stateN = ST_IDLE;
        end else begin
          busyN = 1'b1;
          cntN = cntPrgQ;
          stateN = ST_RUN;
        end
      end
      ST_RUN: begin
        if (!busyQ) begin
          stateN = ST_IDLE;
        end else if (ctlQ[B_RM]) begin
          if (ctlQ[B_STP]) begin
            issue = 1'b1; issueOp = OP_STOP;
          end else if (ctlQ[B_TRX]) begin
            if (txLen != '0) begin
              issue = 1'b1; issueOp = OP_SEND;
            end else begin
              statN[S_XRDY] = 1'b1; stateN = ST_HOLD;
            end
          end else if (rxRoom) begin
            issue = 1'b1; issueOp = OP_RECV;
          end else begin
            statN[S_RRDY] = 1'b1; stateN = ST_HOLD;
          end
        end else if (ctlQ[B_TRX]) begin
          if (!cntZero && txLen != '0) begin
            issue = 1'b1; issueOp = OP_SEND;
          end else begin
            statN[S_XRDY] = !cntZero;
            if (cntZero) finish = 1'b1;
            else stateN = ST_HOLD;
          end
        end else begin
          if (!cntZero && rxRoom) begin
            issue = 1'b1; issueOp = OP_RECV;
          end else begin
            statN[S_RRDY] = (rxLen != '0);
            if (cntZero) finish = 1'b1;
            else stateN = ST_HOLD;
          end
        end
      end
      ST_WAIT: if (busDone) begin
        unique case (opQ)
          OP_SEND: begin
            cmd.popTx = 1'b1;
            if (busNack) begin
              statN[S_NACK] = 1'b1;
              ctlN[B_STP] = 1'b0;
              stateN = ST_HOLD;
            end else begin
              if (!ctlQ[B_RM]) cntN = cntQ - 1'b1;
              stateN = ST_RUN;
            end
          end
          OP_RECV: begin
            cmd.pushRx = 1'b1;
            if (!ctlQ[B_RM]) cntN = cntQ - 1'b1;
            stateN = ST_RUN;
          end
          default: begin
            cmd.clrTx = 1'b1;
            busyN = 1'b0;
            ctlN[B_STP] = 1'b0;
            cntN = cntPrgQ;
            stateN = ST_IDLE;
          end
        endcase
      end
      ST_HOLD: if (ev.bufEvent) stateN = ST_RUN;
      default: ;
    endcase

    if (finish) begin
      if (ctlQ[B_STP]) begin
        issue = 1'b1; issueOp = OP_STOP;
      end else begin
        statN[S_ARDY] = 1'b1;
        ctlN[B_MST] = 1'b0;
        stateN = ST_HOLD;
      end
    end
    if (issue) begin
      reqN = 1'b1; opN = issueOp; stateN = ST_WAIT;
    end
    if (cntWr) cntPrgN = cntIn;

    if (ctlWr) begin
      ctlN = ctlIn & CTL_MASK;
      if (!ctlIn[B_EN]) begin
        if (LEGACY_RESET) begin
          ctlN = '0; cntPrgN = '0; cntN = '0; statN = '0;
          busyN = 1'b0; stateN = ST_IDLE; reqN = 1'b0;
          cmd = '0; cmd.clrAll = 1'b1;
        end
      end else if (startReq) begin
        ctlN[B_STT] = 1'b0;
        reqN = 1'b1; opN = OP_START;
        addrN = tgtAddr; readN = !ctlIn[B_TRX];
        stateN = ST_ADDR;
        cmd.clrAll = 1'b1;
      end else if (stateQ == ST_HOLD) begin
        stateN = ST_RUN;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE; opQ <= OP_START; ctlQ <= '0; cntPrgQ <= '0; cntQ <= '0;
      statQ <= '0; busyQ <= 1'b0; reqQ <= 1'b0; readQ <= 1'b0; addrQ <= '0;
    end else begin
      stateQ <= stateN; opQ <= opN; ctlQ <= ctlN; cntPrgQ <= cntPrgN; cntQ <= cntN;
      statQ <= {statN[4:1], 1'b0}; busyQ <= busyN; reqQ <= reqN;
      readQ <= readN; addrQ <= addrN;
    end
  end

  assign ctlOut  = ctlQ;
  assign cntCur  = cntQ;
  assign status  = statQ;
  assign busBusy = busyQ;
  assign busReq  = reqQ;
  assign busOp   = opQ;
  assign busAddr = addrQ;
  assign busRead = readQ;

  // R1: a valid start write yields a start request and clears the start bit
  a_r1_start_issued: assert property (@(posedge clk) disable iff (!rstN)
    ctlWr && startReq |=> busReq && (busOp == OP_START) && !ctlOut[B_STT]);

  // R8: slave mode or 10-bit mode produce no request
  a_r8_refused: assert property (@(posedge clk) disable iff (!rstN)
    ctlWr && ctlIn[B_EN] && ctlIn[B_STT] && (!ctlIn[B_MST] || ctlIn[B_XA])
    |=> !busReq);

  // R2: refused address phase leaves the bus free and flags NACK
  a_r2_addr_nack: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ADDR) && busDone && busNack && !ctlWr
    |=> !busBusy && status[S_NACK]);

  // R3: each acknowledged counted byte lowers the running count by one
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT) && busDone && (opQ == OP_SEND) && !busNack && !ctlQ[B_RM] && !ctlWr
    |=> cntCur == $past(cntCur) - 1'b1);

  // R6: a refused byte flags NACK and cancels the stop
  a_r6_byte_nack: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT) && busDone && (opQ == OP_SEND) && busNack && !ctlWr
    |=> status[S_NACK] && !ctlOut[B_STP] && !busReq);

  // R4: a finished stop frees the bus and reloads the count
  a_r4_stop_reload: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT) && busDone && (opQ == OP_STOP) && !ctlWr && !cntWr
    |=> !busBusy && (cntCur == cntPrgQ));

  // R5: repeat mode leaves the running count untouched
  a_r5_repeat_count: assert property (@(posedge clk) disable iff (!rstN)
    busyQ && ctlQ[B_RM] && !ctlWr && !((stateQ == ST_WAIT) && (opQ == OP_STOP))
    |=> $stable(cntCur));
endmodule

// File: rtl/xfer_seq_top.sv
module xfer_seq_top
  import xfer_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int ADDR_W = 10,
  parameter int DEPTH = 4,
  parameter bit LEGACY_RESET = 1'b1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWr,
  input  logic [15:0]       ctlIn,
  output logic [15:0]       ctlOut,
  input  logic              cntWr,
  input  logic [CNT_W-1:0]  cntIn,
  output logic [CNT_W-1:0]  cntCur,
  input  logic [ADDR_W-1:0] tgtAddr,
  input  logic              datWr,
  input  logic              datByte,
  input  logic [15:0]       datIn,
  input  logic              datRd,
  output logic [15:0]       datOut,
  input  logic [4:0]        statClr,
  output logic [4:0]        status,
  output logic              busBusy,
  output logic              busReq,
  output logic [1:0]        busOp,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRead,
  output logic [7:0]        busWdata,
  input  logic              busDone,
  input  logic              busNack,
  input  logic [7:0]        busRdata
);
  dpCmd_t        cmd;
  dpEv_t         ev;
  logic [LW-1:0] txLen, rxLen;

  xfer_seq_ctrl #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .LEGACY_RESET(LEGACY_RESET)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .ctlIn(ctlIn), .ctlOut(ctlOut),
    .cntWr(cntWr), .cntIn(cntIn), .cntCur(cntCur), .tgtAddr(tgtAddr),
    .statClr(statClr), .status(status), .busBusy(busBusy), .busReq(busReq),
    .busOp(busOp), .busAddr(busAddr), .busRead(busRead), .busDone(busDone),
    .busNack(busNack), .busRdata(busRdata), .txLen(txLen), .rxLen(rxLen),
    .ev(ev), .cmd(cmd)
  );

  xfer_seq_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .bigEnd(ctlOut[B_BE]),
    .datWr(datWr), .datByte(datByte), .datIn(datIn), .datRd(datRd),
    .datOut(datOut), .txByte(busWdata), .txLen(txLen), .rxLen(rxLen), .ev(ev)
  );
endmodule

// File: tb/sim_xfer_seq_top.sv
`timescale 1ns/1ps
module sim_xfer_seq_top;
  localparam logic [15:0] C_EN = 16'h8000, C_BE = 16'h4000, C_MST = 16'h0400,
                          C_TRX = 16'h0200, C_XA = 16'h0100, C_RM = 16'h0004,
                          C_STP = 16'h0002, C_STT = 16'h0001;
  localparam int SETTLE = 40;

  logic clk = 1'b0, rstN = 1'b0;
  logic ctlWr = 0, cntWr = 0, datWr = 0, datByte = 0, datRd = 0;
  logic [15:0] ctlIn = '0, cntIn = '0, datIn = '0;
  logic [9:0] tgtAddr = 10'h2A5;
  logic [4:0] statClr = '0;
  logic [15:0] ctlOut, cntCur, datOut;
  logic [4:0] status;
  logic busBusy, busReq, busRead;
  logic [1:0] busOp;
  logic [9:0] busAddr;
  logic [7:0] busWdata;
  logic busDone = 0, busNack = 0;
  logic [7:0] busRdata = '0;

  int nChk = 0, nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xfer_seq_top u0 (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .ctlIn(ctlIn), .ctlOut(ctlOut),
    .cntWr(cntWr), .cntIn(cntIn), .cntCur(cntCur), .tgtAddr(tgtAddr),
    .datWr(datWr), .datByte(datByte), .datIn(datIn), .datRd(datRd), .datOut(datOut),
    .statClr(statClr), .status(status), .busBusy(busBusy), .busReq(busReq),
    .busOp(busOp), .busAddr(busAddr), .busRead(busRead), .busWdata(busWdata),
    .busDone(busDone), .busNack(busNack), .busRdata(busRdata)
  );

  // byte-level bus agent model
  int unsigned sentTotal = 0, startCnt = 0, stopCnt = 0, nackAbs = 1000;
  bit addrNackEn = 0;
  logic [7:0] rxNext = 8'hA0;
  logic [7:0] logB [0:63];
  logic [1:0] pendOp = 2'd0;
  int lat = 0;
  logic [9:0] lastAddr = '0;
  logic lastRead = 0;

  always @(posedge clk) begin
    busDone <= 1'b0;
    busNack <= 1'b0;
    if (busReq) begin
      pendOp <= busOp;
      lat <= 2;
      if (busOp == 2'd0) begin
        startCnt <= startCnt + 1;
        lastAddr <= busAddr;
        lastRead <= busRead;
      end
    end else if (lat != 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        busDone <= 1'b1;
        case (pendOp)
          2'd0: busNack <= addrNackEn;
          2'd1: begin
            busNack <= (sentTotal == nackAbs);
            logB[sentTotal[5:0]] <= busWdata;
            sentTotal <= sentTotal + 1;
          end
          2'd2: begin
            busRdata <= rxNext;
            rxNext <= rxNext + 1'b1;
          end
          default: stopCnt <= stopCnt + 1;
        endcase
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic wrCtl(input logic [15:0] v);
    @(negedge clk); ctlIn = v; ctlWr = 1;
    @(negedge clk); ctlWr = 0;
    settle();
  endtask

  task automatic wrCnt(input logic [15:0] v);
    @(negedge clk); cntIn = v; cntWr = 1;
    @(negedge clk); cntWr = 0;
  endtask

  task automatic wrDat(input logic [15:0] v);
    @(negedge clk); datIn = v; datByte = 0; datWr = 1;
    @(negedge clk); datWr = 0;
    settle();
  endtask

  task automatic rdDat();
    @(negedge clk); datRd = 1;
    @(negedge clk); datRd = 0;
    settle();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  endtask

  typedef struct packed {
    logic [7:0] cnt;
    logic       stp;
    logic [3:0] nackIdx;
    logic [3:0] expSent;
    logic [7:0] expCnt;
    logic [4:0] expStat;
    logic       expBusy;
    logic       expMst;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{8'd4, 1'b1, 4'd15, 4'd4, 8'd4, 5'h00, 1'b0, 1'b1},
    '{8'd4, 1'b0, 4'd15, 4'd4, 8'd0, 5'h04, 1'b1, 1'b0},
    '{8'd3, 1'b1, 4'd15, 4'd3, 8'd3, 5'h00, 1'b0, 1'b1},
    '{8'd2, 1'b0, 4'd15, 4'd2, 8'd0, 5'h04, 1'b1, 1'b0},
    '{8'd4, 1'b1, 4'd1,  4'd4, 8'd1, 5'h12, 1'b1, 1'b1},
    '{8'd0, 1'b0, 4'd15, 4'd0, 8'd0, 5'h04, 1'b1, 1'b0}
  };

  initial begin
    #(8 * 150000);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int unsigned base, st0, sp0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // reset state
    chk("reset status", status, 5'h00);
    chk("reset busBusy", busBusy, 1'b0);
    chk("reset busReq", busReq, 1'b0);
    chk("R9 reset cntCur", cntCur, 16'h0);
    chk("R7 reset ctlOut", ctlOut, 16'h0);

    // R7 mask and R8 10-bit refusal
    st0 = startCnt;
    wrCtl(16'hFFFF);
    chk("R7 ctl mask readback", ctlOut, 16'hCF87);
    chk("R8 10-bit no start", startCnt - st0, 0);
    chk("R8 10-bit bus idle", busBusy, 1'b0);

    // R8 slave refusal
    wrCtl(16'h0000);
    st0 = startCnt;
    wrCtl(C_EN | C_TRX | C_STT);
    chk("R8 slave no start", startCnt - st0, 0);
    chk("R8 slave bus idle", busBusy, 1'b0);

    // R2 address refused, R1 start fields
    wrCtl(16'h0000);
    addrNackEn = 1;
    st0 = startCnt;
    wrCtl(C_EN | C_MST | C_TRX | C_STP | C_STT);
    addrNackEn = 0;
    chk("R1 one start", startCnt - st0, 1);
    chk("R1 start address", lastAddr, 10'h2A5);
    chk("R1 transmit direction", lastRead, 1'b0);
    chk("R2 nack flag", status[1], 1'b1);
    chk("R2 stop cleared, R1 start cleared", ctlOut, 16'h8600);
    chk("R2 bus not busy", busBusy, 1'b0);
    @(negedge clk); statClr = 5'h02;
    @(negedge clk); statClr = 5'h00;
    chk("R2 nack cleared by statClr", status, 5'h00);

    // counted transmit table (R3 R4 R6 R9)
    for (int i = 0; i < NV; i++) begin
      wrCtl(16'h0000);
      chk("R7 legacy reset status", status, 5'h00);
      base = sentTotal;
      nackAbs = (VEC[i].nackIdx == 4'd15) ? 1000 : base + VEC[i].nackIdx;
      wrCnt({8'h00, VEC[i].cnt});
      wrCtl(C_EN | C_MST | C_TRX | (VEC[i].stp ? C_STP : 16'h0) | C_STT);
      wrDat(16'h2211);
      wrDat(16'h4433);
      chk($sformatf("R3 vec%0d bytes sent", i), sentTotal - base, VEC[i].expSent);
      chk($sformatf("R9 vec%0d running count", i), cntCur, VEC[i].expCnt);
      chk($sformatf("R4 R6 vec%0d status", i), status, VEC[i].expStat);
      chk($sformatf("R4 vec%0d busy", i), busBusy, VEC[i].expBusy);
      chk($sformatf("R4 vec%0d master bit", i), ctlOut[10], VEC[i].expMst);
      if (i == 0) chk("R10 little-endian first byte", logB[base[5:0]], 8'h11);
      nackAbs = 1000;
    end

    // R10 big-endian transmit
    wrCtl(16'h0000);
    base = sentTotal;
    wrCnt(16'd1);
    wrCtl(C_EN | C_BE | C_MST | C_TRX | C_STP | C_STT);
    wrDat(16'h2211);
    chk("R10 big-endian first byte", logB[base[5:0]], 8'h22);
    chk("R4 single byte then idle", busBusy, 1'b0);

    // R5 repeat receive, R11 refill after read
    wrCtl(16'h0000);
    wrCnt(16'd5);
    wrCtl(C_EN | C_MST | C_RM | C_STT);
    chk("R1 receive direction", lastRead, 1'b1);
    chk("R5 receive-ready after fill", status[3], 1'b1);
    chk("R5 repeat count unchanged", cntCur, 16'd5);
    chk("R10 oldest byte low", datOut, 16'hA1A0);
    rdDat();
    chk("R11 refill after read", datOut, 16'hA3A2);
    chk("R5 R11 repeat count after refill", cntCur, 16'd5);
    sp0 = stopCnt;
    wrCtl(C_EN | C_MST | C_RM | C_STP);
    chk("R5 stop ends repeat", busBusy, 1'b0);
    chk("R5 one stop", stopCnt - sp0, 1);

    // R3 counted receive with stop, R10 drain
    wrCtl(16'h0000);
    wrCnt(16'd3);
    wrCtl(C_EN | C_MST | C_STP | C_STT);
    chk("R3 counted receive ready", status[3], 1'b1);
    chk("R4 receive stop frees bus", busBusy, 1'b0);
    chk("R4 count reloaded", cntCur, 16'd3);
    chk("R10 received order", datOut, 16'hA7A6);
    rdDat();
    chk("R10 last odd byte", datOut[7:0], 8'hA8);
    chk("R10 ready kept while held", status[3], 1'b1);
    rdDat();
    chk("R10 ready cleared when empty", status[3], 1'b0);

    // R7 legacy reset of count
    wrCtl(16'h0000);
    chk("R7 legacy reset count", cntCur, 16'h0);
    chk("R7 legacy reset busy", busBusy, 1'b0);

    summary();
  end
endmodule